// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block sits between a host register port and a byte-wide peripheral bus. It turns one host access into a single address or data transfer that follows the EPP 1.9 handshake. The host names the target port with a select line and pulses a write or read request. The engine then pulls its ready output low and runs the transfer with the peripheral. The handshake is an interlock on the peripheral's wait line. The engine drives the bus, nWRITE and one of two active-low strobes. It finishes each phase only when the peripheral's wait line has changed level.

A watchdog limits how long one transfer may take. If the peripheral stalls for longer than a configurable time (10 µs by default), the transfer is abandoned and a sticky timeout flag is set. The host clears that flag with a one-cycle clear pulse.

Two control inputs from the port's control register change the bus behaviour. The first is a bus-input bit. When it is set at the moment a write is requested, the write cannot reach the bus, and the peripheral sees a read-like cycle instead. The second is a strobe-override bit. While it is set, the bus is held in output mode and nWRITE is held asserted.

The wait line passes through a parameterised synchroniser, so the engine sees each change of nWAIT a few clock cycles late.

Top module: `epp_cycle_engine`

## Requirements
- R1: One cycle after a request is accepted, host_ready goes low. It stays low until the transfer completes or is aborted. A request is accepted only while host_ready is high; requests made while host_ready is low are ignored.
- R2: If n_wait is high when a transfer starts, the outputs pd_out, pd_oe, n_write, n_datastb and n_addrstb keep their values until n_wait has been seen low.
- R3: If n_wait is low when a transfer starts, the engine goes on to assert a strobe without waiting. It ends the strobe only after n_wait has gone high.
- R4: On a write, the engine first drives the byte on pd_out, sets pd_oe to 1 and sets n_write to 0. It asserts the strobe at least one cycle later. host_sel_addr=1 selects n_addrstb and host_sel_addr=0 selects n_datastb. pd_out, pd_oe and n_write do not change while the strobe is low.
- R5: On a write, once n_wait is seen high, the strobe goes high and host_ready goes high in the same cycle. n_write, pd_oe and pd_out keep their values until n_wait has been seen low again, even when a new transfer has already been requested.
- R6: On a read, n_write is 1 and pd_oe is 0 while the strobe is low. host_rdata takes the value of pd_in in the cycle the strobe is released.
- R7: If a transfer has not completed within TO_CYCLES clock cycles of its request (1250 cycles at the defaults, which is 10 µs at 125 MHz), it is aborted. Both strobes go high, host_ready goes high and stat_timeout becomes 1. The abort never happens earlier than TO_CYCLES cycles after the request.
- R8: stat_timeout stays 1 until a cycle in which stat_clr is 1. If an abort and a clear fall in the same cycle, the flag is set.
- R9: A write requested while ctl_bus_in=1 runs on the bus as a read-like cycle, with n_write=1 and pd_oe=0. It does not set stat_timeout and it does not change host_rdata.
- R10: While ctl_strobe_ovr=1, pd_oe is 1 and n_write is 0 whatever the state of the transfer.
- R11: After reset, host_ready=1, both strobes are high, n_write=1, pd_oe=0 and stat_timeout=0. The two strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel_addr | input | 1 | Port select: 1 selects the address port, 0 the data port |
| host_wr | input | 1 | Write request pulse |
| host_rd | input | 1 | Read request pulse |
| host_wdata | input | 8 | Byte to write |
| host_rdata | output | 8 | Byte captured by the last read |
| host_ready | output | 1 | Low while a transfer is in progress |
| ctl_bus_in | input | 1 | Control bit that keeps the bus as an input |
| ctl_strobe_ovr | input | 1 | Control override that forces output mode and nWRITE asserted |
| stat_clr | input | 1 | Clear pulse for the timeout flag |
| stat_timeout | output | 1 | Sticky watchdog timeout flag (status bit 0) |
| pd_out | output | 8 | Byte driven onto the peripheral bus |
| pd_in | input | 8 | Byte read from the peripheral bus |
| pd_oe | output | 1 | Bus drive enable, 1 means output |
| n_write | output | 1 | Active-low write indication |
| n_datastb | output | 1 | Active-low data strobe |
| n_addrstb | output | 1 | Active-low address strobe |
| n_wait | input | 1 | Peripheral wait/handshake line |

## Verification
A wrong state shows first at the strobes and at host_ready. A strobe that is asserted before n_wait has been seen low, or a host_ready that rises before n_wait has been seen high, appears within the synchroniser delay plus one cycle. The bench holds n_wait at each level for many cycles so that such early moves cannot be missed.

If the hold state is lost, n_write or pd_oe change while n_wait is still high after a write. This is visible at the moment the next request is accepted.

A wrong read path shows at host_rdata once the transfer ends. A watchdog count that is off shows as a release that comes too early or too late, measured against TO_CYCLES.

// File: rtl/epp_pkg.sv
package epp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ARM,
      ST_SETUP,
      ST_STRB
   } epp_state_t;
endpackage

// File: rtl/epp_wait_sync.sv
module epp_wait_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   generate
      if (STAGES == 0) begin : g_pass
         assign sync_out = async_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], async_in};
         end
         assign sync_out = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
   parameter int LIMIT = 1250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (!run) cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
   import epp_pkg::*;
#(
   parameter int DW          = 8,
   parameter int CLK_KHZ     = 125000,
   parameter int TIMEOUT_US  = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_sel_addr,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   output logic          host_ready,
   input  logic          ctl_bus_in,
   input  logic          ctl_strobe_ovr,
   input  logic          stat_clr,
   output logic          stat_timeout,
   output logic [DW-1:0] pd_out,
   input  logic [DW-1:0] pd_in,
   output logic          pd_oe,
   output logic          n_write,
   output logic          n_datastb,
   output logic          n_addrstb,
   input  logic          n_wait
);
   localparam int TO_CYCLES = (CLK_KHZ / 1000) * TIMEOUT_US;

   generate
      if (SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0, 2, 3 or 4");
      end
      if (TO_CYCLES < 16) begin : g_bad_to
         $error("watchdog limit too small");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   epp_state_t    state;
   logic          wait_s;
   logic          wd_expired;
   logic          sel_addr_q, is_wr_q, drv_wr_q;
   logic [DW-1:0] wbuf_q, pd_q, rdata_q;
   logic          oe_q, nwr_q, nds_q, nas_q, to_q;
   logic          done_now;

   epp_wait_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .async_in(n_wait), .sync_out(wait_s)
   );

   epp_watchdog #(.LIMIT(TO_CYCLES)) i_wd (
      .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .expired(wd_expired)
   );

   assign done_now = (state == ST_STRB) && wait_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         sel_addr_q <= 1'b0;
         is_wr_q    <= 1'b0;
         drv_wr_q   <= 1'b0;
         wbuf_q     <= '0;
         pd_q       <= '0;
         rdata_q    <= '0;
         oe_q       <= 1'b0;
         nwr_q      <= 1'b1;
         nds_q      <= 1'b1;
         nas_q      <= 1'b1;
         to_q       <= 1'b0;
      end else begin
         if (stat_clr) to_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (host_wr || host_rd) begin
                  sel_addr_q <= host_sel_addr;
                  is_wr_q    <= host_wr;
                  drv_wr_q   <= host_wr && !ctl_bus_in;
                  wbuf_q     <= host_wdata;
                  state      <= ST_ARM;
               end
            end
            ST_ARM: begin
               if (!wait_s) begin
                  if (drv_wr_q) pd_q <= wbuf_q;
                  oe_q  <= drv_wr_q;
                  nwr_q <= !drv_wr_q;
                  state <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               nds_q <= sel_addr_q;
               nas_q <= !sel_addr_q;
               state <= ST_STRB;
            end
            ST_STRB: begin
               if (wait_s) begin
                  nds_q <= 1'b1;
                  nas_q <= 1'b1;
                  if (!is_wr_q) rdata_q <= pd_in;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
         if (wd_expired && !done_now) begin
            nds_q <= 1'b1;
            nas_q <= 1'b1;
            to_q  <= 1'b1;
            state <= ST_IDLE;
         end
      end
   end

   assign host_ready   = (state == ST_IDLE);
   assign host_rdata   = rdata_q;
   assign stat_timeout = to_q;
   assign pd_out       = pd_q;
   assign pd_oe        = oe_q | ctl_strobe_ovr;
   assign n_write      = nwr_q & ~ctl_strobe_ovr;
   assign n_datastb    = nds_q;
   assign n_addrstb    = nas_q;
endmodule

// File: rtl/epp_cycle_checker.sv
module epp_cycle_checker #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_wr,
   input logic          host_rd,
   input logic          host_ready,
   input logic          ctl_strobe_ovr,
   input logic          stat_clr,
   input logic          stat_timeout,
   input logic [DW-1:0] pd_out,
   input logic          pd_oe,
   input logic          n_write,
   input logic          n_datastb,
   input logic          n_addrstb
);
   logic strb;
   assign strb = !n_datastb || !n_addrstb;

   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready && (host_wr || host_rd) |=> !host_ready); // R1

   AST_STROBE_STALLS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      strb |-> !host_ready); // R1

   AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!n_datastb && !n_addrstb)); // R11

   AST_BUS_STABLE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (strb && $past(strb) && $stable(ctl_strobe_ovr))
         |-> ($stable(n_write) && $stable(pd_out) && $stable(pd_oe))); // R4

   AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stat_timeout && !stat_clr |=> stat_timeout); // R8

   AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_timeout) |-> (host_ready && n_datastb && n_addrstb)); // R7
endmodule

bind epp_cycle_engine epp_cycle_checker #(.DW(DW)) i_chk (.*);

// File: tb/test_epp_cycle_engine.sv
`timescale 1ns/1ps
module test_epp_cycle_engine;
   localparam int TO_CYCLES = 1250;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel_addr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       host_ready;
   logic       ctl_bus_in = 1'b0, ctl_strobe_ovr = 1'b0, stat_clr = 1'b0;
   logic       stat_timeout;
   logic [7:0] pd_out;
   logic [7:0] pd_in = '0;
   logic       pd_oe, n_write, n_datastb, n_addrstb;
   logic       n_wait = 1'b1;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   epp_cycle_engine i_epp_cycle_engine (
      .clk(clk), .rst_n(rst_n),
      .host_sel_addr(host_sel_addr), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
      .ctl_bus_in(ctl_bus_in), .ctl_strobe_ovr(ctl_strobe_ovr),
      .stat_clr(stat_clr), .stat_timeout(stat_timeout),
      .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe), .n_write(n_write),
      .n_datastb(n_datastb), .n_addrstb(n_addrstb), .n_wait(n_wait)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic request(input bit wr, input bit addr, input logic [7:0] d);
      @(negedge clk);
      host_wr = wr; host_rd = !wr; host_sel_addr = addr; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
   endtask

   task automatic wait_strobe(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (!n_datastb || !n_addrstb) begin seen = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic wait_ready(input int lim, output int n);
      n = 0;
      while (!host_ready && n < lim) begin @(negedge clk); n++; end
   endtask

   task automatic t_reset;
      chk("R11 ready", host_ready, 1);
      chk("R11 strobes", {n_datastb, n_addrstb}, 2'b11);
      chk("R11 n_write", n_write, 1);
      chk("R11 pd_oe", pd_oe, 0);
      chk("R11 timeout", stat_timeout, 0);
   endtask

   task automatic t_write_wait_high;
      bit s; int n;
      n_wait = 1'b1;
      request(1'b1, 1'b0, 8'h3C);
      chk("R1 ready low", host_ready, 0);
      repeat (10) @(negedge clk);
      chk("R2 strobes held", {n_datastb, n_addrstb}, 2'b11);
      chk("R2 n_write held", n_write, 1);
      chk("R2 pd_oe held", pd_oe, 0);
      request(1'b0, 1'b0, 8'h00);
      n_wait = 1'b0;
      wait_strobe(s);
      chk("R4 data strobe", {n_datastb, n_addrstb}, 2'b01);
      chk("R4 pd_out", pd_out, 8'h3C);
      chk("R4 pd_oe", pd_oe, 1);
      chk("R4 n_write", n_write, 0);
      repeat (6) @(negedge clk);
      chk("R3 strobe kept until wait high", n_datastb, 0);
      chk("R1 ready low in strobe", host_ready, 0);
      n_wait = 1'b1;
      wait_ready(40, n);
      chk("R5 strobe released", n_datastb, 1);
      chk("R5 n_write kept", n_write, 0);
   endtask

   task automatic t_hold_then_read;
      bit s; int n;
      request(1'b0, 1'b0, 8'h00);
      repeat (8) @(negedge clk);
      chk("R5 n_write hold", n_write, 0);
      chk("R5 pd_oe hold", pd_oe, 1);
      chk("R5 pd_out hold", pd_out, 8'h3C);
      chk("R2 no strobe", {n_datastb, n_addrstb}, 2'b11);
      n_wait = 1'b0;
      wait_strobe(s);
      chk("R6 read strobe", n_datastb, 0);
      chk("R6 n_write", n_write, 1);
      chk("R6 pd_oe", pd_oe, 0);
      pd_in = 8'h5A;
      repeat (3) @(negedge clk);
      n_wait = 1'b1;
      wait_ready(40, n);
      chk("R6 rdata", host_rdata, 8'h5A);
      n_wait = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_addr_wait_low;
      bit s; int n;
      n_wait = 1'b0;
      request(1'b1, 1'b1, 8'hC3);
      wait_strobe(s);
      chk("R3 strobe seen", s, 1);
      chk("R4 addr strobe", {n_datastb, n_addrstb}, 2'b10);
      chk("R4 addr data", pd_out, 8'hC3);
      n_wait = 1'b1;
      wait_ready(40, n);
      chk("R3 completes", host_ready, 1);
      chk("R3 strobe high", n_addrstb, 1);
      n_wait = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_timeout;
      bit s; int n;
      n_wait = 1'b0;
      request(1'b1, 1'b0, 8'h11);
      wait_strobe(s);
      wait_ready(3 * TO_CYCLES, n);
      chk("R7 not early", (n + 8 >= TO_CYCLES) ? 1 : 0, 1);
      chk("R7 not late", (n <= TO_CYCLES + 4) ? 1 : 0, 1);
      chk("R7 strobes high", {n_datastb, n_addrstb}, 2'b11);
      chk("R7 flag", stat_timeout, 1);
      repeat (5) @(negedge clk);
      chk("R8 sticky", stat_timeout, 1);
      stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
      chk("R8 cleared", stat_timeout, 0);
   endtask

   task automatic t_bus_in_write;
      bit s; int n;
      ctl_bus_in = 1'b1;
      n_wait = 1'b0;
      pd_in = 8'h77;
      request(1'b1, 1'b0, 8'hEE);
      wait_strobe(s);
      chk("R9 strobe", n_datastb, 0);
      chk("R9 n_write", n_write, 1);
      chk("R9 pd_oe", pd_oe, 0);
      n_wait = 1'b1;
      wait_ready(40, n);
      chk("R9 no timeout", stat_timeout, 0);
      chk("R9 rdata kept", host_rdata, 8'h5A);
      ctl_bus_in = 1'b0;
      n_wait = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_override;
      bit s; int n;
      @(negedge clk);
      ctl_strobe_ovr = 1'b1;
      #1;
      chk("R10 idle oe", pd_oe, 1);
      chk("R10 idle n_write", n_write, 0);
      request(1'b0, 1'b0, 8'h00);
      wait_strobe(s);
      chk("R10 read oe", pd_oe, 1);
      chk("R10 read n_write", n_write, 0);
      n_wait = 1'b1;
      wait_ready(40, n);
      @(negedge clk);
      ctl_strobe_ovr = 1'b0;
      #1;
      chk("R10 released", n_write, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_wait_high();
      t_hold_then_read();
      t_addr_wait_low();
      t_timeout();
      t_bus_in_write();
      t_override();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule